// File: doc/BRIEF.md
# Logarithmic Threshold-Gate Parity Network

This block computes the parity of a wide input word with a chain of only K "at most" threshold gates, where K = ceil(log2(N_IN+1)). It uses no XOR tree. The input is padded with constant zeros to 2^K - 1 bits. Every gate sees each padded input bit with weight 1. Every gate also sees the output of each higher-indexed gate, with a weight equal to 2 raised to that gate's index. Gate j fires when its weighted sum does not exceed 2^K - 1 - 2^j. The chain is evaluated from the top gate down, so each gate resolves one bit of the input popcount, the way a binary search does.

The raw gate outputs leave the block as an inverted count vector, because gate j is 1 exactly when bit j of the popcount is 0. The parity output is the inverse of the lowest gate, XORed with a polarity select. A parameter picks the counting structure. The gates can share one popcount, or each gate can count the inputs itself. The block is purely combinational.

Top module: `thresh_parity`

## Requirements
- R1: With flip_i = 0, parity_o equals the XOR of all bits of data_i, so it is 1 when an odd number of input bits are set.
- R2: With flip_i = 1, parity_o is the inverse of the value given by R1. This is the XOR of all inputs together with an extra constant 1.
- R3: cnt_n_o is K = ceil(log2(N_IN+1)) bits wide. Bit j of cnt_n_o is 1 exactly when bit j of the number of set bits in data_i is 0. Bit 0 is the least significant bit.
- R4: When data_i is all zeros, cnt_n_o is all ones and parity_o equals flip_i.
- R5: When all 2^K - 1 input bits are set (N_IN = 15), cnt_n_o is all zeros and parity_o equals the inverse of flip_i.
- R6: When N_IN is not of the form 2^K - 1 (for example 40, which gives K = 6), the results equal those of the padded width with the extra inputs held at 0.
- R7: SHARE_COUNT = 1 (one shared popcount) and SHARE_COUNT = 0 (one popcount per gate) give identical outputs for every input.
- R8: With N_IN = 3, the network has two gates and still meets R1 to R3 for all 8 input patterns.
- R9: The block holds no state. Both outputs depend only on the present data_i and flip_i, and they are valid in the same cycle as the stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | N_IN | Input bits whose parity is computed |
| flip_i | input | 1 | Polarity select: 0 gives plain XOR, 1 gives its inverse |
| parity_o | output | 1 | Parity result |
| cnt_n_o | output | K | Raw gate outputs, the bitwise inverse of the low K popcount bits |

## Verification
Both results are due zero cycles after the stimulus, because no register lies on any path. The bench drives a new input one time unit after a rising clock edge. It samples three time units later, well before the next rising edge, so every check reads settled combinational values inside the same period. The 15-input and 3-input configurations are swept over every input pattern with both polarities. The 40-input configuration gets random words plus the all-zero and all-one words. Every instance is compared against an arithmetic popcount and XOR computed in the bench.

// File: rtl/tpar_pkg.sv
package tpar_pkg;

   // Number of gates needed for n inputs.
   function automatic int gate_count(input int n);
      return $clog2(n + 1);
   endfunction

   // Firing limit of gate j in a chain of k gates.
   function automatic int gate_limit(input int k, input int j);
      return (2 ** k) - 1 - (2 ** j);
   endfunction

endpackage

// File: rtl/tpar_popcnt.sv
module tpar_popcnt #(
   parameter int W  = 15,
   parameter int SW = 5
) (
   input  logic [W-1:0]  din,
   output logic [SW-1:0] cnt
);
   if (SW < $clog2(W + 1)) begin : g_bad_width
      $error("tpar_popcnt: count width too small");
   end

   always_comb begin
      cnt = '0;
      for (int b = 0; b < W; b++) begin
         cnt = cnt + SW'(din[b]);
      end
   end
endmodule

// File: rtl/tpar_gate.sv
module tpar_gate
   import tpar_pkg::*;
#(
   parameter int K  = 4,
   parameter int J  = 0,
   parameter int SW = 5
) (
   input  logic [SW-1:0] in_cnt,
   input  logic [K-1:0]  upper,
   output logic          le
);
   localparam int LIMIT = gate_limit(K, J);

   if (J < 0 || J >= K) begin : g_bad_index
      $error("tpar_gate: gate index out of range");
   end

   logic [SW-1:0] wsum;

   always_comb begin
      wsum = in_cnt;
      for (int i = J + 1; i < K; i++) begin
         if (upper[i]) begin
            wsum = wsum + (SW'(1) << i);
         end
      end
      le = (wsum <= SW'(LIMIT));
   end
endmodule

// File: rtl/thresh_parity.sv
module thresh_parity
   import tpar_pkg::*;
#(
   parameter int  N_IN        = 15,
   parameter bit  SHARE_COUNT = 1'b1,
   localparam int K           = gate_count(N_IN)
) (
   input  logic [N_IN-1:0] data_i,
   input  logic            flip_i,
   output logic            parity_o,
   output logic [K-1:0]    cnt_n_o
);
   localparam int PADW = (2 ** K) - 1;
   localparam int SW   = K + 1;

   if (N_IN < 1) begin : g_bad_n
      $error("thresh_parity: N_IN must be at least 1");
   end
   if (K > 20) begin : g_bad_k
      $error("thresh_parity: too many inputs");
   end

   logic [PADW-1:0] padded;
   assign padded = PADW'(data_i);

   logic [SW-1:0] shared_cnt;

   if (SHARE_COUNT) begin : g_shared
      tpar_popcnt #(.W(PADW), .SW(SW)) u_cnt (
         .din (padded),
         .cnt (shared_cnt)
      );
   end else begin : g_no_shared
      assign shared_cnt = '0;
   end

   for (genvar j = K - 1; j >= 0; j--) begin : g_st
      logic [K-1:0]  hi;
      logic [K-1:0]  hi_out;
      logic [SW-1:0] c;
      logic          q;

      if (j == K - 1) begin : g_top
         assign hi = '0;
      end else begin : g_link
         assign hi = g_st[j+1].hi_out;
      end

      if (SHARE_COUNT) begin : g_use_shared
         assign c = shared_cnt;
      end else begin : g_own
         tpar_popcnt #(.W(PADW), .SW(SW)) u_cnt (
            .din (padded),
            .cnt (c)
         );
      end

      tpar_gate #(.K(K), .J(j), .SW(SW)) u_gate (
         .in_cnt (c),
         .upper  (hi),
         .le     (q)
      );

      assign hi_out = hi | (K'(q) << j);
   end

   assign cnt_n_o  = g_st[0].hi_out;
   assign parity_o = ~g_st[0].q ^ flip_i;
endmodule

// File: rtl/thresh_parity_chk.sv
module thresh_parity_chk #(
   parameter int N_IN = 15,
   parameter int K    = 4
) (
   input logic [N_IN-1:0] data_i,
   input logic            flip_i,
   input logic            parity_o,
   input logic [K-1:0]    cnt_n_o
);
   int ones;
   always_comb begin
      ones = $countones(data_i);
      // R1 / R2: parity tracks the low bit of the count and the polarity
      p_parity_r1: assert (parity_o == (ones[0] ^ flip_i))
         else $error("parity mismatch");
      // R3: inverted count bits
      p_invcnt_r3: assert (cnt_n_o == ~ones[K-1:0])
         else $error("inverted count mismatch");
      // R4: zero input gives all-ones gate outputs
      if (ones == 0) begin
         p_zero_r4: assert (&cnt_n_o && parity_o == flip_i)
            else $error("zero input case wrong");
      end
      // R2: parity agrees with the lowest gate
      p_pol_r2: assert (parity_o == (~cnt_n_o[0] ^ flip_i))
         else $error("polarity mismatch");
   end
endmodule

bind thresh_parity thresh_parity_chk #(.N_IN(N_IN), .K(K)) u_chk (
   .data_i   (data_i),
   .flip_i   (flip_i),
   .parity_o (parity_o),
   .cnt_n_o  (cnt_n_o)
);

// File: tb/thresh_parity_test.sv
module thresh_parity_test;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   logic [14:0] d15;
   logic [2:0]  d3;
   logic [39:0] d40;
   logic        flip;

   logic       par_a, par_b, par_t, par_w;
   logic [3:0] cn_a, cn_b;
   logic [1:0] cn_t;
   logic [5:0] cn_w;

   thresh_parity #(.N_IN(15), .SHARE_COUNT(1'b1)) uut (
      .data_i(d15), .flip_i(flip), .parity_o(par_a), .cnt_n_o(cn_a));
   thresh_parity #(.N_IN(15), .SHARE_COUNT(1'b0)) uut_b (
      .data_i(d15), .flip_i(flip), .parity_o(par_b), .cnt_n_o(cn_b));
   thresh_parity #(.N_IN(3), .SHARE_COUNT(1'b0)) uut_t (
      .data_i(d3), .flip_i(flip), .parity_o(par_t), .cnt_n_o(cn_t));
   thresh_parity #(.N_IN(40), .SHARE_COUNT(1'b1)) uut_w (
      .data_i(d40), .flip_i(flip), .parity_o(par_w), .cnt_n_o(cn_w));

   task automatic chk(input bit ok, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [14:0] a, input logic [2:0] t,
                        input logic [39:0] w, input logic f);
      @(posedge clk);
      #1;
      d15 = a; d3 = t; d40 = w; flip = f;
      #3;
   endtask

   task automatic check_all(input bit do15, input bit do3, input bit do40);
      int pc;
      if (do15) begin
         pc = $countones(d15);
         // R1 R2 parity, R3 inverted count, R7 variant agreement
         chk(par_a == (pc[0] ^ flip), flip ? "R2 parity15" : "R1 parity15",
             64'(par_a), 64'(pc[0] ^ flip));
         chk(cn_a == ~pc[3:0], "R3 count15", 64'(cn_a), 64'(~pc[3:0]));
         chk(par_b == (pc[0] ^ flip) && cn_b == ~pc[3:0], "R7 per-gate count",
             64'({cn_b, par_b}), 64'({~pc[3:0], pc[0] ^ flip}));
      end
      if (do3) begin
         pc = $countones(d3);
         chk(par_t == (pc[0] ^ flip) && cn_t == ~pc[1:0], "R8 three inputs",
             64'({cn_t, par_t}), 64'({~pc[1:0], pc[0] ^ flip}));
      end
      if (do40) begin
         pc = $countones(d40);
         chk(par_w == (pc[0] ^ flip) && cn_w == ~pc[5:0], "R6 padded width",
             64'({cn_w, par_w}), 64'({~pc[5:0], pc[0] ^ flip}));
      end
   endtask

   initial begin
      d15 = '0; d3 = '0; d40 = '0; flip = 1'b0;
      // R4: reset-like all-zero state
      apply('0, '0, '0, 1'b0);
      chk(cn_a == 4'hF && par_a == 1'b0, "R4 zero flip0", 64'({cn_a, par_a}), 64'h1E);
      apply('0, '0, '0, 1'b1);
      chk(cn_a == 4'hF && par_a == 1'b1, "R4 zero flip1", 64'({cn_a, par_a}), 64'h1F);
      chk(cn_w == 6'h3F && par_w == 1'b1, "R4 zero wide", 64'({cn_w, par_w}), 64'h7F);
      // R5: all inputs set
      apply('1, '1, '1, 1'b0);
      chk(cn_a == 4'h0 && par_a == 1'b1, "R5 ones flip0", 64'({cn_a, par_a}), 64'h1);
      apply('1, '1, '1, 1'b1);
      chk(cn_a == 4'h0 && par_a == 1'b0, "R5 ones flip1", 64'({cn_a, par_a}), 64'h0);
      chk(cn_w == 6'h17 && par_w == 1'b1, "R6 forty ones", 64'({cn_w, par_w}), 64'h2F);
      // R9: same input, same output after an unrelated prior pattern
      apply(15'h1234, 3'd5, 40'h0, 1'b0);
      check_all(1, 1, 1);
      apply(15'h1234, 3'd5, 40'h0, 1'b0);
      chk(par_a == 1'b1 && cn_a == 4'hA, "R9 stateless",
          64'({cn_a, par_a}), 64'h15);
      // exhaustive sweep, both polarities
      for (int f = 0; f < 2; f++) begin
         for (int v = 0; v < 32768; v++) begin
            apply(15'(v), 3'(v), {25'h0, 15'(v)}, f[0]);
            check_all(1, v < 8, (v % 97) == 0);
         end
      end
      // random wide words
      for (int r = 0; r < 3000; r++) begin
         apply(15'($urandom), 3'($urandom),
               {8'($urandom), 32'($urandom)}, 1'($urandom));
         check_all(1, 0, 1);
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(5ns * 150000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule